// File: doc/BRIEF.md
# Sparse-Space Bus Address Translator

This block sits between a host port and a PCI master engine. Host software reaches PCI memory and PCI I/O through a sparse window. In that window the target byte offset is shifted five bits to the left, and the freed low address bits carry the transfer size. The block decodes the host region and recovers the PCI offset. For memory cycles it takes the upper PCI address bits from a software-loaded extension register. It then issues one PCI cycle with the byte enables and data lanes set for the size and offset.

A host request is taken through a valid/ready pair. The block then drives a single PCI cycle, or two back-to-back longword cycles for a 64-bit access, and returns one response through a second valid/ready pair. Only one request is in flight at a time. Malformed requests get an error response and no PCI cycle is issued for them.

Top module: `sparse_xlat`

## Requirements
- R1: Host address bits [33:32] select the region: 0 is PCI memory (pci_io_o low), 1 is PCI I/O (pci_io_o high), and 2 or 3 return an error response with no PCI cycle.
- R2: Host address bits [4:3] give the size: 0 is a byte, 1 is a 16-bit word, 3 is a 32-bit longword, and code 2 returns an error response with no PCI cycle.
- R3: The offset is host address bits [31:5]. A memory cycle drives pci_addr_o = {ext[4:0], offset[26:2], 2'b00}. An I/O cycle drives the same value with the top five bits zero.
- R4: Byte enable bit i covers PCI data bits [8i+7:8i]. With lane b = offset[1:0], a byte enables 1<<b, a word enables 3<<b, and a longword enables all four lanes.
- R5: A word request at lane 3 returns an error response with no PCI cycle.
- R6: On a byte or word write, the low 8 or 16 bits of req_wdata_i are moved to lane b of pci_wdata_o and the other lanes are driven zero. A longword write drives req_wdata_i[31:0].
- R7: On a read, the addressed byte or word is shifted down from lane b and zero-extended in rsp_rdata_o. A longword read returns all 32 bits. Write responses and error responses carry zero data.
- R8: With req_quad_i high and size 3, two longword cycles are issued. The second cycle is at offset+4, wrapping within the 27-bit offset field. The first cycle carries data bits [31:0] and the second carries bits [63:32]. A quad request of any other size returns an error response with no PCI cycle.
- R9: A CSR write loads the 5-bit extension register, which resets to zero. A request accepted in the same cycle as the CSR write still uses the old value. Every later request uses the new value.
- R10: req_ready_o is high only while no request is in flight. pci_req_o, pci_addr_o, pci_be_o and pci_wdata_o hold steady until pci_ack_i. rsp_valid_o and the response hold steady until rsp_ready_i.
- R11: After reset, req_ready_o is high and pci_req_o and rsp_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Host request accepted when high with valid |
| req_addr_i | input | 34 | Sparse host address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_quad_i | input | 1 | 64-bit access split into two longwords |
| req_wdata_i | input | 64 | Write data, byte/word in the low bits |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken |
| rsp_rdata_o | output | 64 | Read data, zero-extended |
| rsp_err_o | output | 1 | Request rejected, no PCI cycle issued |
| csr_we_i | input | 1 | Extension register write strobe |
| csr_wdata_i | input | 5 | New extension value (PCI address bits 31:27) |
| pci_req_o | output | 1 | PCI cycle request |
| pci_ack_i | input | 1 | PCI cycle completes this clock |
| pci_io_o | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| pci_write_o | output | 1 | 1 = write cycle |
| pci_addr_o | output | 32 | Longword-aligned PCI address |
| pci_be_o | output | 4 | Byte enables, bit i = lane i |
| pci_wdata_o | output | 32 | Lane-steered write data |
| pci_rdata_i | input | 32 | Read data, valid with pci_ack_i |

## Verification
The stimulus covers bytes at all four lanes, words at lanes 0, 1 and 2, and aligned longwords. The data patterns in the unused lanes differ, so a lane-steering or extraction error shows up as a wrong value. Memory and I/O requests are issued with a non-zero extension value, which separates the path that merges the extension from the one that zeroes it. Quad requests are run in both directions and once at the very top of the offset field, which exposes a wrong beat order, a wrong second address and a carry out of the offset field. The reserved size, the lane-3 word, the unmapped regions and a quad request with a non-longword size must each return an error with no PCI cycle. Further runs stall the PCI acknowledge, hold off the response, and land a CSR write in the same cycle a request is accepted.

// File: rtl/sparse_xlat_pkg.sv
package sparse_xlat_pkg;

  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DW     = LANES * LANE_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_RSVD = 2'd2,
    SZ_LONG = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BUS,
    ST_RSP
  } state_e;

  typedef struct packed {
    size_e      size;
    logic [1:0] lane;
  } lane_sel_t;

endpackage

// File: rtl/sparse_ext_reg.sv
module sparse_ext_reg #(
  parameter int EXT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [EXT_W-1:0] wdata_i,
  output logic [EXT_W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end

endmodule

// File: rtl/sparse_decode.sv
module sparse_decode
  import sparse_xlat_pkg::*;
#(
  parameter int HADDR_W    = 34,
  parameter int PADDR_W    = 32,
  parameter int OFS_W      = 27,
  parameter int MEM_REGION = 0,
  parameter int IO_REGION  = 1,
  localparam int EXT_W     = PADDR_W - OFS_W,
  localparam int REG_W     = HADDR_W - OFS_W - 5
) (
  input  logic [HADDR_W-1:0] addr_i,
  input  logic               quad_i,
  input  logic [EXT_W-1:0]   ext_i,
  output logic [PADDR_W-1:0] pci_addr_o,
  output logic               io_o,
  output lane_sel_t          sel_o,
  output logic [LANES-1:0]   be_o,
  output logic               err_o
);

  logic [REG_W-1:0] region;
  logic [OFS_W-1:0] ofs;
  size_e            size;
  logic             hit_mem, hit_io;
  logic             unused_low;

  assign region     = addr_i[HADDR_W-1 -: REG_W];
  assign ofs        = addr_i[OFS_W+4:5];
  assign size       = size_e'(addr_i[4:3]);
  assign unused_low = ^addr_i[2:0];

  assign hit_mem = (region == REG_W'(MEM_REGION));
  assign hit_io  = (region == REG_W'(IO_REGION));

  // I/O space never takes the extension bits
  assign pci_addr_o = {hit_io ? {EXT_W{1'b0}} : ext_i, ofs[OFS_W-1:2], 2'b00};
  assign io_o       = hit_io;
  assign sel_o      = '{size: size, lane: ofs[1:0]};

  always_comb begin
    unique case (size)
      SZ_BYTE: be_o = 4'b0001 << ofs[1:0];
      SZ_WORD: be_o = 4'b0011 << ofs[1:0];
      SZ_LONG: be_o = 4'b1111;
      default: be_o = 4'b0000;
    endcase
  end

  assign err_o = !(hit_mem || hit_io)
              || (size == SZ_RSVD)
              || (size == SZ_WORD && ofs[1:0] == 2'd3)
              || (quad_i && size != SZ_LONG);

endmodule

// File: rtl/sparse_lane.sv
module sparse_lane
  import sparse_xlat_pkg::*;
(
  input  lane_sel_t        sel_i,
  input  logic             hi_i,
  input  logic [2*DW-1:0]  wdata_i,
  input  logic [DW-1:0]    pci_rdata_i,
  output logic [DW-1:0]    pci_wdata_o,
  output logic [DW-1:0]    rdata_o
);

  logic [4:0]    shift;
  logic [DW-1:0] rsh;

  assign shift = {sel_i.lane, 3'b000};
  assign rsh   = pci_rdata_i >> shift;

  always_comb begin
    unique case (sel_i.size)
      SZ_BYTE: begin
        pci_wdata_o = {{(DW-8){1'b0}}, wdata_i[7:0]} << shift;
        rdata_o     = {{(DW-8){1'b0}}, rsh[7:0]};
      end
      SZ_WORD: begin
        pci_wdata_o = {{(DW-16){1'b0}}, wdata_i[15:0]} << shift;
        rdata_o     = {{(DW-16){1'b0}}, rsh[15:0]};
      end
      default: begin
        pci_wdata_o = hi_i ? wdata_i[2*DW-1:DW] : wdata_i[DW-1:0];
        rdata_o     = pci_rdata_i;
      end
    endcase
  end

endmodule

// File: rtl/sparse_xlat.sv
module sparse_xlat
  import sparse_xlat_pkg::*;
#(
  parameter int HADDR_W    = 34,
  parameter int PADDR_W    = 32,
  parameter int OFS_W      = 27,
  parameter int MEM_REGION = 0,
  parameter int IO_REGION  = 1,
  localparam int EXT_W     = PADDR_W - OFS_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [HADDR_W-1:0] req_addr_i,
  input  logic               req_write_i,
  input  logic               req_quad_i,
  input  logic [2*DW-1:0]    req_wdata_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [2*DW-1:0]    rsp_rdata_o,
  output logic               rsp_err_o,
  input  logic               csr_we_i,
  input  logic [EXT_W-1:0]   csr_wdata_i,
  output logic               pci_req_o,
  input  logic               pci_ack_i,
  output logic               pci_io_o,
  output logic               pci_write_o,
  output logic [PADDR_W-1:0] pci_addr_o,
  output logic [LANES-1:0]   pci_be_o,
  output logic [DW-1:0]      pci_wdata_o,
  input  logic [DW-1:0]      pci_rdata_i
);

  state_e             state_q;
  logic [EXT_W-1:0]   ext_q;
  logic [PADDR_W-1:0] dec_addr, addr_q;
  logic               dec_io, dec_err;
  lane_sel_t          dec_sel, sel_q;
  logic [LANES-1:0]   dec_be, be_q;
  logic               io_q, write_q, quad_q, beat_q, err_q;
  logic [2*DW-1:0]    wdata_q, rdata_q;
  logic [DW-1:0]      lane_rd;

  sparse_ext_reg #(.EXT_W(EXT_W)) ext_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (csr_we_i),
    .wdata_i (csr_wdata_i),
    .q_o     (ext_q)
  );

  sparse_decode #(
    .HADDR_W    (HADDR_W),
    .PADDR_W    (PADDR_W),
    .OFS_W      (OFS_W),
    .MEM_REGION (MEM_REGION),
    .IO_REGION  (IO_REGION)
  ) dec_i (
    .addr_i     (req_addr_i),
    .quad_i     (req_quad_i),
    .ext_i      (ext_q),
    .pci_addr_o (dec_addr),
    .io_o       (dec_io),
    .sel_o      (dec_sel),
    .be_o       (dec_be),
    .err_o      (dec_err)
  );

  sparse_lane lane_i (
    .sel_i       (sel_q),
    .hi_i        (beat_q),
    .wdata_i     (wdata_q),
    .pci_rdata_i (pci_rdata_i),
    .pci_wdata_o (pci_wdata_o),
    .rdata_o     (lane_rd)
  );

  // the whole beat is latched at accept, so ext changes after that are invisible
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      io_q    <= 1'b0;
      write_q <= 1'b0;
      quad_q  <= 1'b0;
      beat_q  <= 1'b0;
      sel_q   <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q  <= dec_addr;
          io_q    <= dec_io;
          write_q <= req_write_i;
          quad_q  <= req_quad_i;
          beat_q  <= 1'b0;
          sel_q   <= dec_sel;
          be_q    <= dec_be;
          wdata_q <= req_wdata_i;
          rdata_q <= '0;
          err_q   <= dec_err;
          state_q <= dec_err ? ST_RSP : ST_BUS;
        end
        ST_BUS: if (pci_ack_i) begin
          if (!write_q) begin
            if (beat_q) rdata_q[2*DW-1:DW] <= lane_rd;
            else        rdata_q[DW-1:0]    <= lane_rd;
          end
          if (quad_q && !beat_q) begin
            beat_q <= 1'b1;
            addr_q <= {addr_q[PADDR_W-1:OFS_W], addr_q[OFS_W-1:0] + OFS_W'(4)};
          end else begin
            state_q <= ST_RSP;
          end
        end
        ST_RSP: if (rsp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign pci_req_o   = (state_q == ST_BUS);
  assign rsp_valid_o = (state_q == ST_RSP);
  assign pci_io_o    = io_q;
  assign pci_write_o = write_q;
  assign pci_addr_o  = addr_q;
  assign pci_be_o    = be_q;
  assign rsp_rdata_o = rdata_q;
  assign rsp_err_o   = err_q;

  // R1, R5 and R8 rejections share this path
  p_err_no_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && dec_err |=> rsp_valid_o && rsp_err_o && !pci_req_o);

  p_byte_be_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_req_o && sel_q.size == SZ_BYTE |-> $countones(pci_be_o) == 1);

  p_word_be_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_req_o && sel_q.size == SZ_WORD |-> $countones(pci_be_o) == 2);

  p_quad_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_req_o && pci_ack_i && quad_q && !beat_q |=>
      pci_req_o && pci_addr_o[OFS_W-1:0] == $past(pci_addr_o[OFS_W-1:0]) + OFS_W'(4));

  p_bus_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_req_o && !pci_ack_i |=> pci_req_o && $stable(pci_addr_o)
      && $stable(pci_be_o) && $stable(pci_wdata_o));

  p_rsp_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_rdata_o) && $stable(rsp_err_o));

endmodule

// File: tb/sparse_xlat_tb.sv
module sparse_xlat_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [33:0] req_addr_i = '0;
  logic        req_write_i = 1'b0;
  logic        req_quad_i = 1'b0;
  logic [63:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b1;
  logic [63:0] rsp_rdata_o;
  logic        rsp_err_o;
  logic        csr_we_i = 1'b0;
  logic [4:0]  csr_wdata_i = '0;
  logic        pci_req_o;
  logic        pci_ack_i;
  logic        pci_io_o;
  logic        pci_write_o;
  logic [31:0] pci_addr_o;
  logic [3:0]  pci_be_o;
  logic [31:0] pci_wdata_o;
  logic [31:0] pci_rdata_i;

  logic        ack_en = 1'b1;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [4:0]  ext_m = '0;

  // 250 MHz
  always #2 clk_i = ~clk_i;

  sparse_xlat dut_i (.*);

  function automatic logic [31:0] rd_pat(input logic [31:0] a);
    return {a[7:0] ^ 8'hF0, 8'hB2, 8'hA1, a[7:0]};
  endfunction

  assign pci_ack_i   = pci_req_o && ack_en;
  assign pci_rdata_i = rd_pat(pci_addr_o);

  // PCI beat monitor
  int          mon_n = 0;
  logic [31:0] mon_addr [2];
  logic [3:0]  mon_be   [2];
  logic [31:0] mon_wd   [2];
  logic        mon_io   [2];
  logic        mon_wr   [2];

  always @(negedge clk_i) begin
    if (pci_req_o && pci_ack_i && mon_n < 2) begin
      mon_addr[mon_n] = pci_addr_o;
      mon_be[mon_n]   = pci_be_o;
      mon_wd[mon_n]   = pci_wdata_o;
      mon_io[mon_n]   = pci_io_o;
      mon_wr[mon_n]   = pci_write_o;
      mon_n           = mon_n + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  logic        got_err;
  logic [63:0] got_rd;

  task automatic issue(input logic [1:0] rg, input logic [26:0] ofs, input logic [1:0] sz,
                       input logic wr, input logic q, input logic [63:0] wd,
                       input logic csr_same, input logic [4:0] csr_val);
    @(negedge clk_i);
    mon_n       = 0;
    req_addr_i  = {rg, ofs, sz, 3'b000};
    req_write_i = wr;
    req_quad_i  = q;
    req_wdata_i = wd;
    req_valid_i = 1'b1;
    if (csr_same) begin
      csr_we_i    = 1'b1;
      csr_wdata_i = csr_val;
    end
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    csr_we_i    = 1'b0;
  endtask

  task automatic wait_rsp();
    while (!rsp_valid_o) @(negedge clk_i);
    got_err = rsp_err_o;
    got_rd  = rsp_rdata_o;
  endtask

  task automatic csr_write(input logic [4:0] v);
    @(negedge clk_i);
    csr_we_i    = 1'b1;
    csr_wdata_i = v;
    @(negedge clk_i);
    csr_we_i    = 1'b0;
    ext_m       = v;
  endtask

  task automatic check_txn(input logic [1:0] rg, input logic [26:0] ofs, input logic [1:0] sz,
                           input logic wr, input logic q, input logic [63:0] wd,
                           input logic exp_err, input logic [3:0] exp_be);
    logic [26:0] ofs1;
    logic [31:0] a0, a1, wd0, r0;
    logic [4:0]  sh;
    logic [63:0] exp_rd;
    ofs1 = ofs + 27'd4;
    a0   = {(rg == 2'd1) ? 5'd0 : ext_m, ofs[26:2], 2'b00};
    a1   = {(rg == 2'd1) ? 5'd0 : ext_m, ofs1[26:2], 2'b00};
    sh   = {ofs[1:0], 3'b000};
    wd0  = (sz == 2'd3) ? wd[31:0]
         : (sz == 2'd1) ? ({16'h0, wd[15:0]} << sh) : ({24'h0, wd[7:0]} << sh);
    r0   = rd_pat(a0) >> sh;
    if (exp_err || wr)  exp_rd = '0;
    else if (q)         exp_rd = {rd_pat(a1), rd_pat(a0)};
    else if (sz == 2'd3) exp_rd = {32'h0, rd_pat(a0)};
    else if (sz == 2'd1) exp_rd = {48'h0, r0[15:0]};
    else                exp_rd = {56'h0, r0[7:0]};

    chk("R1 R2 R5 R8 error flag", got_err, exp_err);
    chk("R7 response data", got_rd, exp_rd);
    if (exp_err) begin
      chk("R2 no PCI cycle on error", mon_n, 0);
    end else begin
      chk("R8 beat count", mon_n, q ? 2 : 1);
      chk("R1 io select", mon_io[0], rg == 2'd1);
      chk("R3 address", mon_addr[0], a0);
      chk("R4 byte enables", mon_be[0], exp_be);
      chk("R6 write flag", mon_wr[0], wr);
      if (wr) chk("R6 write lanes", mon_wd[0], wd0);
      if (q) begin
        chk("R8 second address", mon_addr[1], a1);
        chk("R8 second enables", mon_be[1], 4'hF);
        if (wr) chk("R8 second data", mon_wd[1], wd[63:32]);
      end
    end
  endtask

  // {region, offset, size, write, quad, wdata, err, be}
  localparam int NV = 17;
  localparam logic [101:0] VEC [NV] = '{
    {2'd0, 27'h0000010, 2'd0, 1'b0, 1'b0, 64'h0,                  1'b0, 4'b0001},
    {2'd0, 27'h0000011, 2'd0, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFAB, 1'b0, 4'b0010},
    {2'd0, 27'h0000013, 2'd0, 1'b0, 1'b0, 64'h0,                  1'b0, 4'b1000},
    {2'd0, 27'h0000022, 2'd1, 1'b1, 1'b0, 64'h9999_9999_7777_BEEF, 1'b0, 4'b1100},
    {2'd0, 27'h0000021, 2'd1, 1'b0, 1'b0, 64'h0,                  1'b0, 4'b0110},
    {2'd0, 27'h0000023, 2'd1, 1'b0, 1'b0, 64'h0,                  1'b1, 4'b0000},
    {2'd0, 27'h0000040, 2'd3, 1'b1, 1'b0, 64'hAAAA_AAAA_1234_5678, 1'b0, 4'b1111},
    {2'd1, 27'h0000081, 2'd0, 1'b0, 1'b0, 64'h0,                  1'b0, 4'b0010},
    {2'd1, 27'h0000084, 2'd3, 1'b1, 1'b0, 64'h0000_0000_CAFE_F00D, 1'b0, 4'b1111},
    {2'd0, 27'h0000012, 2'd2, 1'b0, 1'b0, 64'h0,                  1'b1, 4'b0000},
    {2'd2, 27'h0000010, 2'd0, 1'b0, 1'b0, 64'h0,                  1'b1, 4'b0000},
    {2'd0, 27'h0000200, 2'd3, 1'b0, 1'b1, 64'h0,                  1'b0, 4'b1111},
    {2'd0, 27'h0000300, 2'd3, 1'b1, 1'b1, 64'h1122_3344_5566_7788, 1'b0, 4'b1111},
    {2'd0, 27'h0000010, 2'd0, 1'b0, 1'b1, 64'h0,                  1'b1, 4'b0000},
    {2'd1, 27'h0000400, 2'd3, 1'b0, 1'b1, 64'h0,                  1'b0, 4'b1111},
    {2'd0, 27'h7FFFFFF, 2'd0, 1'b0, 1'b0, 64'h0,                  1'b0, 4'b1000},
    {2'd0, 27'h7FFFFFC, 2'd3, 1'b0, 1'b1, 64'h0,                  1'b0, 4'b1111}
  };

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #600000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    logic [63:0] held_rd;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk("R11 ready after reset", req_ready_o, 1'b1);
    chk("R11 no PCI request after reset", pci_req_o, 1'b0);
    chk("R11 no response after reset", rsp_valid_o, 1'b0);
    rst_ni = 1'b1;

    // R9 extension resets to zero
    issue(2'd0, 27'h10, 2'd0, 1'b0, 1'b0, 64'h0, 1'b0, 5'h0);
    wait_rsp();
    chk("R9 extension after reset", mon_addr[0][31:27], 5'h0);

    csr_write(5'h0A);
    for (int i = 0; i < NV; i++) begin
      logic [101:0] v;
      v = VEC[i];
      issue(v[101:100], v[99:73], v[72:71], v[70], v[69], v[68:5], 1'b0, 5'h0);
      wait_rsp();
      check_txn(v[101:100], v[99:73], v[72:71], v[70], v[69], v[68:5], v[4], v[3:0]);
    end

    // R9 CSR write in the accept cycle uses the old value
    issue(2'd0, 27'h10, 2'd0, 1'b0, 1'b0, 64'h0, 1'b1, 5'h1F);
    wait_rsp();
    chk("R9 same-cycle request keeps old extension", mon_addr[0][31:27], 5'h0A);
    ext_m = 5'h1F;
    issue(2'd0, 27'h44, 2'd1, 1'b0, 1'b0, 64'h0, 1'b0, 5'h0);
    wait_rsp();
    chk("R9 later request takes new extension", mon_addr[0][31:27], 5'h1F);
    check_txn(2'd0, 27'h44, 2'd1, 1'b0, 1'b0, 64'h0, 1'b0, 4'b0011);

    // R10 PCI stall: request held, no second request taken
    ack_en = 1'b0;
    issue(2'd0, 27'h52, 2'd0, 1'b1, 1'b0, 64'h5C, 1'b0, 5'h0);
    held = pci_addr_o;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk("R10 PCI request held during stall", pci_req_o, 1'b1);
      chk("R10 PCI address stable during stall", pci_addr_o, held);
      chk("R10 not ready while busy", req_ready_o, 1'b0);
    end
    ack_en = 1'b1;
    wait_rsp();
    check_txn(2'd0, 27'h52, 2'd0, 1'b1, 1'b0, 64'h5C, 1'b0, 4'b0100);

    // R10 response back-pressure
    @(negedge clk_i);
    rsp_ready_i = 1'b0;
    issue(2'd1, 27'h10, 2'd3, 1'b0, 1'b0, 64'h0, 1'b0, 5'h0);
    wait_rsp();
    held_rd = got_rd;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk_i);
      chk("R10 response held", rsp_valid_o, 1'b1);
      chk("R10 response data stable", rsp_rdata_o, held_rd);
    end
    rsp_ready_i = 1'b1;
    @(negedge clk_i);
    chk("R10 response released", rsp_valid_o, 1'b0);
    chk("R7 io longword read", held_rd, {32'h0, rd_pat({5'h0, 25'h4, 2'b00})});

    repeat (2) @(negedge clk_i);
    finish_run();
  end

endmodule